// File: doc/BRIEF.md
# Vector Twin-Predicate Mask Generator

This block turns the predicate fields of a vector instruction into two per-element enable masks. One mask governs which source elements are read and the other governs which destination elements are written. A single mode bit decides whether both masks come from general-purpose integer registers or both come from 4-bit condition fields. The two sources are never mixed. Each side has its own 3-bit selector, and the two selectors share one encoding, so both sides may name the same register or two different ones.

The issue stage presents the selectors, three integer register values, the packed condition fields and the vector length, and pulses a request. One clock later the block returns both masks, an illegal-instruction flag and a one-cycle done pulse. Between requests the results stay unchanged. Mask bits at and above the vector length are always zero. A reserved integer selector raises the trap flag and blanks both masks.

Top module: `vpred_mask_gen`

## Requirements
- R1: `pred_mode`=0 makes both sides use integer-register decoding, and `pred_mode`=1 makes both sides use condition-field decoding. One side cannot be integer while the other is condition-based.
- R2: In integer mode, selector 3'b000 enables every element below `vl`.
- R3: In integer mode, selector 3'b001 on either side sets `illegal`=1 and drives both masks to all-zero. In condition mode, 3'b001 is a legal code.
- R4: In integer mode, selectors 3'b010/3'b011 read `reg_a`, 3'b100/3'b101 read `reg_b`, and 3'b110/3'b111 read `reg_c`. Element i is enabled when bit i of that register is 1 for an even selector, or 0 for an odd selector.
- R5: In condition mode, element i reads field 6+i. Field k occupies `cond_fields[4k+3:4k]`, with bit 3 = less-than, bit 2 = greater-than, bit 1 = equal and bit 0 = summary-overflow. Selector bits [2:1] pick the flag: 00 less-than, 01 greater-than, 10 equal, 11 summary-overflow. Selector bit 0 = 0 enables the element when the flag is 1, and bit 0 = 1 enables it when the flag is 0.
- R6: In condition mode, an element whose field number 6+i is not below NUM_CRF is disabled, whatever selector bit 0 says.
- R7: Mask bits at positions `vl` and above are 0. `vl` ranges over 0..MAXVL.
- R8: `done` is high exactly in the cycle after a cycle with `req_valid` high. The masks and `illegal` for that request are valid in the same cycle.
- R9: After reset, all outputs are 0. The outputs change only in response to a request, and input changes without a request have no effect.
- R10: The source and destination masks are decoded independently from `src_sel` and `dst_sel`. Both selectors may name the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe; inputs are sampled on this cycle |
| pred_mode | input | 1 | 0 = integer predication, 1 = condition-field predication |
| src_sel | input | 3 | Source predicate selector |
| dst_sel | input | 3 | Destination predicate selector |
| reg_a | input | XLEN | First integer predicate register value |
| reg_b | input | XLEN | Second integer predicate register value |
| reg_c | input | XLEN | Third integer predicate register value |
| cond_fields | input | 4*NUM_CRF | Packed condition fields, field k at bits [4k+3:4k] |
| vl | input | $clog2(MAXVL+1) | Vector length |
| done | output | 1 | One-cycle pulse marking valid results |
| src_mask | output | MAXVL | Source element enables |
| dst_mask | output | MAXVL | Destination element enables |
| illegal | output | 1 | Reserved-selector trap flag |

## Verification
The trap and the ordinary decode of the other side can fall in the same request: one selector holds the reserved integer code while the other selects a live register, so a valid mask is computed and must be suppressed. Vector-length truncation also coincides with every decode, including the condition-field tail where elements run past the last field. The bench sweeps every pairing of mode, source selector, destination selector and vector length over three data patterns on an 8-element configuration. For every request it judges both masks and the trap flag against an element-by-element model. The idle cycle that follows each request has scrambled inputs and must leave the outputs untouched.

// File: rtl/vpred_pkg.sv
package vpred_pkg;
  localparam int FIELD_BITS = 4;

  typedef enum logic {
    PRED_INT = 1'b0,
    PRED_CR  = 1'b1
  } pred_kind_e;

  typedef enum logic [1:0] {
    FLAG_LT = 2'b00,
    FLAG_GT = 2'b01,
    FLAG_EQ = 2'b10,
    FLAG_SO = 2'b11
  } crflag_e;

  // flag order inside one field: LT at the top bit, SO at the bottom
  function automatic logic flag_of(input logic [FIELD_BITS-1:0] field, input crflag_e which);
    return field[FIELD_BITS-1-int'(which)];
  endfunction

  function automatic logic sel_reserved(input pred_kind_e kind, input logic [2:0] sel);
    return (kind == PRED_INT) && (sel == 3'b001);
  endfunction
endpackage

// File: rtl/vpred_int_mask.sv
module vpred_int_mask #(
  parameter int MAXVL = 64,
  parameter int XLEN  = 64
) (
  input  logic [2:0]       sel,
  input  logic [XLEN-1:0]  reg_a,
  input  logic [XLEN-1:0]  reg_b,
  input  logic [XLEN-1:0]  reg_c,
  output logic [MAXVL-1:0] mask
);
  logic [MAXVL-1:0] base;

  always_comb begin
    unique case (sel[2:1])
      2'b00:   base = '1;
      2'b01:   base = MAXVL'(reg_a);
      2'b10:   base = MAXVL'(reg_b);
      default: base = MAXVL'(reg_c);
    endcase
    mask = base ^ {MAXVL{sel[0]}};
  end
endmodule

// File: rtl/vpred_cr_mask.sv
module vpred_cr_mask
  import vpred_pkg::*;
#(
  parameter int MAXVL     = 64,
  parameter int NUM_CRF   = 64,
  parameter int FIRST_CRF = 6
) (
  input  logic [2:0]                    sel,
  input  logic [NUM_CRF*FIELD_BITS-1:0] cond_fields,
  output logic [MAXVL-1:0]              mask
);
  crflag_e which;
  assign which = crflag_e'(sel[2:1]);

  always_comb begin
    mask = '0;
    for (int i = 0; i < MAXVL; i++) begin
      if (FIRST_CRF + i < NUM_CRF)
        mask[i] = flag_of(cond_fields[(FIRST_CRF+i)*FIELD_BITS +: FIELD_BITS], which) ^ sel[0];
    end
  end
endmodule

// File: rtl/vpred_len_mask.sv
module vpred_len_mask #(
  parameter int MAXVL = 64,
  parameter int VLW   = $clog2(MAXVL+1)
) (
  input  logic [VLW-1:0]   vl,
  output logic [MAXVL-1:0] mask
);
  for (genvar i = 0; i < MAXVL; i++) begin : g_bit
    assign mask[i] = (VLW'(i) < vl);
  end
endmodule

// File: rtl/vpred_mask_gen.sv
module vpred_mask_gen
  import vpred_pkg::*;
#(
  parameter int MAXVL     = 64,
  parameter int XLEN      = 64,
  parameter int NUM_CRF   = 64,
  parameter int FIRST_CRF = 6,
  localparam int VLW      = $clog2(MAXVL+1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          pred_mode,
  input  logic [2:0]                    src_sel,
  input  logic [2:0]                    dst_sel,
  input  logic [XLEN-1:0]               reg_a,
  input  logic [XLEN-1:0]               reg_b,
  input  logic [XLEN-1:0]               reg_c,
  input  logic [NUM_CRF*FIELD_BITS-1:0] cond_fields,
  input  logic [VLW-1:0]                vl,
  output logic                          done,
  output logic [MAXVL-1:0]              src_mask,
  output logic [MAXVL-1:0]              dst_mask,
  output logic                          illegal
);
  localparam int SIDES = 2;

  pred_kind_e                   kind;
  logic [SIDES-1:0][2:0]        sel_v;
  logic [SIDES-1:0]             rsv_hit;
  logic [SIDES-1:0][MAXVL-1:0]  int_m, cr_m, side_m;
  logic [MAXVL-1:0]             len_m;
  logic                         trap_next;

  assign kind  = pred_kind_e'(pred_mode);
  assign sel_v = {dst_sel, src_sel};   // index 0 = source side (R10)

  vpred_len_mask #(.MAXVL(MAXVL), .VLW(VLW)) u_len (.vl(vl), .mask(len_m));

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    vpred_int_mask #(.MAXVL(MAXVL), .XLEN(XLEN)) u_int (
      .sel(sel_v[s]), .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c), .mask(int_m[s])
    );
    vpred_cr_mask #(.MAXVL(MAXVL), .NUM_CRF(NUM_CRF), .FIRST_CRF(FIRST_CRF)) u_cr (
      .sel(sel_v[s]), .cond_fields(cond_fields), .mask(cr_m[s])
    );
    assign rsv_hit[s] = sel_reserved(kind, sel_v[s]);
    // R1: one mode bit steers both sides
    assign side_m[s] = ((kind == PRED_CR) ? cr_m[s] : int_m[s]) & len_m & {MAXVL{~trap_next}};
  end

  assign trap_next = |rsv_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      src_mask <= '0;
      dst_mask <= '0;
      illegal  <= 1'b0;
    end else begin
      done <= req_valid;
      if (req_valid) begin
        src_mask <= side_m[0];
        dst_mask <= side_m[1];
        illegal  <= trap_next;
      end
    end
  end
endmodule

// File: rtl/vpred_mask_checks.sv
module vpred_mask_checks #(
  parameter int MAXVL     = 64,
  parameter int NUM_CRF   = 64,
  parameter int FIRST_CRF = 6,
  parameter int VLW       = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             pred_mode,
  input logic [2:0]       src_sel,
  input logic [2:0]       dst_sel,
  input logic [VLW-1:0]   vl,
  input logic             done,
  input logic [MAXVL-1:0] src_mask,
  input logic [MAXVL-1:0] dst_mask,
  input logic             illegal,
  input logic             trap_next
);
  localparam int LIVE = (NUM_CRF > FIRST_CRF) ? NUM_CRF - FIRST_CRF : 0;

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> done);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !done);
  p_trap_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (src_mask == '0 && dst_mask == '0));
  p_trap_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (illegal == (!$past(pred_mode) && ($past(src_sel) == 3'b001 || $past(dst_sel) == 3'b001))));
  p_trap_wire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pred_mode) |-> !trap_next);
  p_vl_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ((src_mask >> $past(vl)) == '0 && (dst_mask >> $past(vl)) == '0));
  p_unmasked_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pred_mode && src_sel == 3'b000 && dst_sel != 3'b001)
      |=> ($countones(src_mask) == int'($past(vl))));
  p_cr_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pred_mode) |=> ((src_mask >> LIVE) == '0 && (dst_mask >> LIVE) == '0));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(src_mask) && $stable(dst_mask) && $stable(illegal)));
endmodule

bind vpred_mask_gen vpred_mask_checks #(
  .MAXVL(MAXVL), .NUM_CRF(NUM_CRF), .FIRST_CRF(FIRST_CRF), .VLW(VLW)
) u_checks (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pred_mode(pred_mode),
  .src_sel(src_sel), .dst_sel(dst_sel), .vl(vl), .done(done),
  .src_mask(src_mask), .dst_mask(dst_mask), .illegal(illegal), .trap_next(trap_next)
);

// File: tb/vpred_mask_gen_test.sv
module vpred_mask_gen_test;
  localparam int MAXVL = 8;
  localparam int XLEN  = 8;
  localparam int NCRF  = 12;
  localparam int VLW   = $clog2(MAXVL+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic pred_mode = 1'b0;
  logic [2:0] src_sel = '0, dst_sel = '0;
  logic [XLEN-1:0] reg_a = '0, reg_b = '0, reg_c = '0;
  logic [NCRF*4-1:0] cond_fields = '0;
  logic [VLW-1:0] vl = '0;
  logic done, illegal;
  logic [MAXVL-1:0] src_mask, dst_mask;

  int vectors = 0;
  int misses = 0;
  bit finished = 0;
  logic [31:0] lcg = 32'h1234_5678;

  always #10 clk = ~clk;  // 50 MHz

  vpred_mask_gen #(.MAXVL(MAXVL), .XLEN(XLEN), .NUM_CRF(NCRF), .FIRST_CRF(6)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pred_mode(pred_mode),
    .src_sel(src_sel), .dst_sel(dst_sel), .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c),
    .cond_fields(cond_fields), .vl(vl), .done(done), .src_mask(src_mask),
    .dst_mask(dst_mask), .illegal(illegal)
  );

  function automatic logic [31:0] step(input logic [31:0] x);
    return x * 32'd1664525 + 32'd1013904223;
  endfunction

  // element-by-element model of the requirements
  function automatic logic [MAXVL-1:0] model(input logic m, input logic [2:0] s, input int len,
      input logic [XLEN-1:0] a, input logic [XLEN-1:0] b, input logic [XLEN-1:0] c,
      input logic [NCRF*4-1:0] cr);
    logic [MAXVL-1:0] r = '0;
    for (int i = 0; i < MAXVL; i++) begin
      int bitv;
      if (i >= len) continue;                       // R7
      if (m == 1'b0) begin
        case (s / 2)                                // R4 register pick
          0: bitv = 1;                              // R2
          1: bitv = (a >> i) & 1;
          2: bitv = (b >> i) & 1;
          default: bitv = (c >> i) & 1;
        endcase
        if (s / 2 != 0 && (s % 2) == 1) bitv = 1 - bitv;
        r[i] = (bitv != 0);
      end else begin
        int k = 6 + i;
        if (k >= NCRF) continue;                    // R6
        bitv = (cr >> (4 * k + 3 - (s / 2))) & 1;   // R5 flag order
        r[i] = ((bitv ^ (s % 2)) != 0);
      end
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic m, input logic [2:0] s, input bit trap);
    if (trap) return "R3";
    if (m) return "R1 R5 R6 R7";
    return (s == 3'b000) ? "R1 R2 R7" : "R1 R4 R7";
  endfunction

  task automatic apply(input logic m, input logic [2:0] ss, input logic [2:0] ds, input int len,
      input logic [XLEN-1:0] a, input logic [XLEN-1:0] b, input logic [XLEN-1:0] c,
      input logic [NCRF*4-1:0] cr);
    bit trap;
    logic [MAXVL-1:0] es, ed;
    trap = (m == 1'b0) && (ss == 3'b001 || ds == 3'b001);
    es = trap ? '0 : model(m, ss, len, a, b, c, cr);
    ed = trap ? '0 : model(m, ds, len, a, b, c, cr);
    pred_mode = m; src_sel = ss; dst_sel = ds; vl = VLW'(len);
    reg_a = a; reg_b = b; reg_c = c; cond_fields = cr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 done after request", 64'(done), 64'd1);
    check({tag_of(m, ss, trap), " R10 src"}, 64'(src_mask), 64'(es));
    check({tag_of(m, ds, trap), " R10 dst"}, 64'(dst_mask), 64'(ed));
    check("R3 trap flag", 64'(illegal), 64'(trap));
    // scramble inputs without a request: nothing may move
    pred_mode = ~m; src_sel = ~ss; dst_sel = ~ds; vl = '0;
    reg_a = ~a; reg_b = ~b; reg_c = ~c; cond_fields = ~cr;
    @(negedge clk);
    check("R8 done single pulse", 64'(done), 64'd0);
    check("R9 hold src", 64'(src_mask), 64'(es));
    check("R9 hold dst", 64'(dst_mask), 64'(ed));
    check("R9 hold trap", 64'(illegal), 64'(trap));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL R8 watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset done", 64'(done), 64'd0);
    check("R9 reset src", 64'(src_mask), 64'd0);
    check("R9 reset dst", 64'(dst_mask), 64'd0);
    check("R9 reset trap", 64'(illegal), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int p = 0; p < 3; p++) begin
      for (int m = 0; m < 2; m++) begin
        for (int ss = 0; ss < 8; ss++) begin
          for (int ds = 0; ds < 8; ds++) begin
            for (int len = 0; len <= MAXVL; len++) begin
              logic [XLEN-1:0] a, b, c;
              logic [NCRF*4-1:0] cr;
              lcg = step(lcg); a = lcg[XLEN+3:4];
              lcg = step(lcg); b = lcg[XLEN+7:8];
              lcg = step(lcg); c = lcg[XLEN+11:12];
              for (int w = 0; w < NCRF * 4; w += 16) begin
                lcg = step(lcg);
                cr[w +: 16] = lcg[23:8];
              end
              if (p == 1) begin a = 8'hA5; b = 8'h0F; c = 8'h3C; cr = {NCRF{4'b1010}}; end
              if (p == 2) begin b = a; c = a; cr = {NCRF{4'b0101}}; end   // R10 shared register
              apply(m[0], ss[2:0], ds[2:0], len, a, b, c, cr);
            end
          end
        end
      end
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule